// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit owns the configuration state that bounds how many elements a banked vector register file can run at once. It stores which of the eight register banks are enabled and how many integer and floating-point registers each element uses. From these it derives the largest legal vector length. When software asks for a length, it grants the smaller of that request and the largest legal length.

Changing the per-element register counts needs an integer division of the per-bank register budget. This division runs in a multi-cycle divider. While it runs, `busy` is high and new length requests or count changes are dropped. A bank-mask write needs no division. The unit keeps the last quotient and multiplies it by the new enabled-bank count, so the new maximum is visible on the next cycle. A packed read word shows both register counts and the granted length.

Top module: `vlcfg_unit`

## Requirements
- R1: After a synchronous reset all banks are enabled (bank_count 8), both register counts are 32, vlmax is 32, vl is 0, busy and done are low, and cfg_rdata reads 0x0082_0000.
- R2: A mask write keeps only the low 8 bits of mask_wdata and drops the bits above them. From the next cycle bank_count equals the number of ones in the stored mask, and vlmax follows the new count. Mask writes are accepted even while busy.
- R3: A configure command given while busy is low is accepted. busy then stays high for exactly 9 cycles. On the cycle busy falls, done is high for a single cycle and vlmax shows the new register counts.
- R4: When the integer count plus the fp count is 2 or more, vlmax is floor(256 / (n_int + n_fp − 1)) times bank_count, before the clamp of R6.
- R5: When the integer count plus the fp count is below 2, vlmax is 256 times bank_count, before the clamp of R6.
- R6: vlmax never exceeds THREAD_MAX; larger products read as THREAD_MAX.
- R7: A set-length request given while busy is low sets vl to min(vlmax, setvl_len) on the next cycle. vlmax is the value present in the cycle of the request.
- R8: While busy is high, set-length requests and configure commands are ignored: vl and the reported register counts stay unchanged.
- R9: cfg_rdata carries the fp count in bits 23:18, the integer count in bits 17:12 and vl in its low bits, all other bits zero. A newly accepted count appears there on the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mask_wr | input | 1 | Write strobe for the bank-enable mask |
| mask_wdata | input | MASK_IN_W (16) | Mask write data; only the low BANKS bits are kept |
| cfg_valid | input | 1 | Configure command strobe |
| cfg_nint | input | 6 | Integer registers used per element |
| cfg_nfp | input | 6 | Floating-point registers used per element |
| setvl_valid | input | 1 | Set-length request strobe |
| setvl_len | input | REQ_W (16) | Requested vector length |
| vlmax | output | clog2(THREAD_MAX+1) (6) | Largest legal vector length |
| vl | output | clog2(THREAD_MAX+1) (6) | Granted vector length |
| bank_count | output | clog2(BANKS+1) (4) | Number of enabled banks |
| cfg_rdata | output | 32 | Packed counts and granted length |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when a new maximum takes effect |

## Verification
The assertions assume that a caller sees `busy` before it relies on a configure command or a set-length request being taken. They also assume the divisor handed to the divider is never zero, which the unit ensures by substituting one for sums below two. The stimulus does not respect `busy`. It sends requests and commands during a division on purpose, so the drop rule is exercised, and it mixes mask writes into every phase. The bench instance raises THREAD_MAX to 1024, so the unclamped budget case and the clamp can both be seen at the ports.

// File: rtl/vlcfg_pkg.sv
// Shared constants and types for the vector length configuration unit.
// Assumes register counts are small unsigned fields of equal width.
package vlcfg_pkg;
    localparam int VLC_CNT_W   = 6;
    localparam int VLC_RST_CNT = 32;
    localparam int VLC_FP_LSB  = 18;
    localparam int VLC_INT_LSB = 12;

    typedef logic [VLC_CNT_W-1:0] vlc_cnt_t;

    typedef struct packed {
        vlc_cnt_t n_fp;
        vlc_cnt_t n_int;
    } vlc_regcfg_t;
endpackage

// File: rtl/vlcfg_popcount.sv
// Counts the ones in a bit vector with a ripple chain of adders.
// Assumes W is wide enough to hold N.
module vlcfg_popcount #(
    parameter int N = 8,
    parameter int W = 4
) (
    input  logic [N-1:0] bits,
    output logic [W-1:0] count
);
    logic [W-1:0] acc [N+1];

    assign acc[0] = '0;

    // one adder stage per input bit
    for (genvar g = 0; g < N; g++) begin : g_stage
        assign acc[g+1] = acc[g] + W'(bits[g]);
    end

    assign count = acc[N];
endmodule

// File: rtl/vlcfg_divider.sv
// Restoring divider of a fixed dividend by a run-time divisor.
// It produces one quotient bit per cycle and takes DVD_W cycles.
// The result register holds the last quotient between runs.
// Assumes the divisor is non-zero when start is taken.
module vlcfg_divider #(
    parameter int DVD_W    = 9,
    parameter int DVS_W    = 7,
    parameter int DIVIDEND = 256,
    parameter int RST_Q    = 4,
    localparam int STEP_W  = $clog2(DVD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [DVD_W-1:0] quotient
);
    logic [DVS_W-1:0]  rem_q;
    logic [DVD_W-1:0]  qr_q;
    logic [DVS_W-1:0]  dvs_q;
    logic [STEP_W-1:0] cnt_q;
    logic [DVS_W:0]    shifted;
    logic [DVS_W:0]    trial;
    logic              ge;
    logic [DVS_W-1:0]  rem_n;
    logic [DVD_W-1:0]  qr_n;

    // one restoring step: shift in the next dividend bit and try to subtract
    always_comb begin
        shifted = {rem_q, qr_q[DVD_W-1]};
        trial   = shifted - {1'b0, dvs_q};
        ge      = (shifted >= {1'b0, dvs_q});
        rem_n   = ge ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
        qr_n    = {qr_q[DVD_W-2:0], ge};
    end

    // sequencing of the division and capture of the finished quotient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            quotient <= DVD_W'(RST_Q);
            rem_q    <= '0;
            qr_q     <= '0;
            dvs_q    <= DVS_W'(1);
            cnt_q    <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                rem_q <= rem_n;
                qr_q  <= qr_n;
                cnt_q <= cnt_q - STEP_W'(1);
                if (cnt_q == STEP_W'(1)) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    quotient <= qr_n;
                end
            end else if (start) begin
                busy  <= 1'b1;
                cnt_q <= STEP_W'(DVD_W);
                rem_q <= '0;
                qr_q  <= DVD_W'(DIVIDEND);
                dvs_q <= divisor;
            end
        end
    end

    // the caller must never start a run with a zero divisor (R4)
    p_div_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (divisor != '0));

    // a finished quotient is the exact floor of the division (R4)
    p_div_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((int'(quotient) * int'(dvs_q) <= DIVIDEND) &&
                  (DIVIDEND - int'(quotient) * int'(dvs_q) < int'(dvs_q))));
endmodule

// File: rtl/vlcfg_limit.sv
// Multiplies the stored quotient by the enabled-bank count and clamps
// the product to the hardware thread limit.
// Assumes LIMIT fits in O_W bits.
module vlcfg_limit #(
    parameter int Q_W   = 9,
    parameter int C_W   = 4,
    parameter int O_W   = 6,
    parameter int LIMIT = 32,
    localparam int P_W  = Q_W + C_W
) (
    input  logic [Q_W-1:0] quot,
    input  logic [C_W-1:0] count,
    output logic [O_W-1:0] result
);
    localparam logic [P_W-1:0] LIM_P = P_W'(LIMIT);

    logic [P_W-1:0] prod;

    // product of budget share and bank count, then saturate
    always_comb begin
        prod   = P_W'(quot) * P_W'(count);
        result = (prod > LIM_P) ? O_W'(LIMIT) : prod[O_W-1:0];
    end
endmodule

// File: rtl/vlcfg_unit.sv
// Vector length configuration unit: holds the bank mask and per-element
// register counts, derives the largest legal vector length and grants
// set-length requests against it.
// Assumes REQ_W >= VL_W and that VL_W leaves bits 17:12 free in cfg_rdata.
module vlcfg_unit
    import vlcfg_pkg::*;
#(
    parameter int BANKS         = 8,
    parameter int REGS_PER_BANK = 256,
    parameter int THREAD_MAX    = 32,
    parameter int MASK_IN_W     = 16,
    parameter int REQ_W         = 16,
    localparam int BC_W    = $clog2(BANKS + 1),
    localparam int DVD_W   = $clog2(REGS_PER_BANK + 1),
    localparam int DVS_W   = VLC_CNT_W + 1,
    localparam int VL_W    = $clog2(THREAD_MAX + 1),
    localparam int RDATA_W = 32,
    localparam int RST_Q   = REGS_PER_BANK / (2 * VLC_RST_CNT - 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_wr,
    input  logic [MASK_IN_W-1:0] mask_wdata,
    input  logic                 cfg_valid,
    input  logic [VLC_CNT_W-1:0] cfg_nint,
    input  logic [VLC_CNT_W-1:0] cfg_nfp,
    input  logic                 setvl_valid,
    input  logic [REQ_W-1:0]     setvl_len,
    output logic [VL_W-1:0]      vlmax,
    output logic [VL_W-1:0]      vl,
    output logic [BC_W-1:0]      bank_count,
    output logic [RDATA_W-1:0]   cfg_rdata,
    output logic                 busy,
    output logic                 done
);
    logic [BANKS-1:0] mask_q;
    vlc_regcfg_t      cfg_q;
    logic [VL_W-1:0]  vl_q;
    logic [DVS_W-1:0] sum;
    logic [DVS_W-1:0] divisor;
    logic [DVD_W-1:0] quot;
    logic             start;
    logic [REQ_W-1:0] vmx_ext;
    logic [VL_W-1:0]  grant;
    logic             unused_mask_hi;

    assign unused_mask_hi = ^mask_wdata[MASK_IN_W-1:BANKS];

    // bank-enable mask keeps only the low BANKS bits of a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_wr) begin
            mask_q <= mask_wdata[BANKS-1:0];
        end
    end

    // register counts are taken only when no division is running
    assign start = cfg_valid && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.n_fp  <= vlc_cnt_t'(VLC_RST_CNT);
            cfg_q.n_int <= vlc_cnt_t'(VLC_RST_CNT);
        end else if (start) begin
            cfg_q.n_fp  <= cfg_nfp;
            cfg_q.n_int <= cfg_nint;
        end
    end

    // divisor is count sum minus one, forced to one for sums below two
    always_comb begin
        sum     = DVS_W'(cfg_nint) + DVS_W'(cfg_nfp);
        divisor = (sum < DVS_W'(2)) ? DVS_W'(1) : (sum - DVS_W'(1));
    end

    vlcfg_divider #(
        .DVD_W    (DVD_W),
        .DVS_W    (DVS_W),
        .DIVIDEND (REGS_PER_BANK),
        .RST_Q    (RST_Q)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .divisor  (divisor),
        .busy     (busy),
        .done     (done),
        .quotient (quot)
    );

    vlcfg_popcount #(
        .N (BANKS),
        .W (BC_W)
    ) u_pop (
        .bits  (mask_q),
        .count (bank_count)
    );

    vlcfg_limit #(
        .Q_W   (DVD_W),
        .C_W   (BC_W),
        .O_W   (VL_W),
        .LIMIT (THREAD_MAX)
    ) u_lim (
        .quot   (quot),
        .count  (bank_count),
        .result (vlmax)
    );

    // grant is the smaller of the request and the current maximum
    always_comb begin
        vmx_ext = REQ_W'(vlmax);
        grant   = (setvl_len < vmx_ext) ? setvl_len[VL_W-1:0] : vlmax;
    end

    // granted length updates only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= '0;
        end else if (setvl_valid && !busy) begin
            vl_q <= grant;
        end
    end

    assign vl = vl_q;

    // packed read word: fp count, integer count, granted length
    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[VLC_FP_LSB  +: VLC_CNT_W] = cfg_q.n_fp;
        cfg_rdata[VLC_INT_LSB +: VLC_CNT_W] = cfg_q.n_int;
        cfg_rdata[VL_W-1:0]                 = vl_q;
    end

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_mask_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (int'(bank_count) == $countones($past(mask_wdata[BANKS-1:0]))));

    p_bank_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bank_count) <= BANKS);

    p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(vlmax) <= THREAD_MAX);

    p_grant_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_valid && !busy) |=> ((vl <= $past(vlmax)) &&
            ((vl == $past(vlmax)) || (REQ_W'(vl) == $past(setvl_len)))));

    p_vl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (setvl_valid && busy) |=> $stable(vl));

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && busy) |=> $stable(cfg_rdata));
endmodule

// File: tb/tb_vlcfg_unit.sv
module tb_vlcfg_unit;
    localparam int PER  = 20;
    localparam int TMAX = 1024;
    localparam int VW   = $clog2(TMAX + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_wr = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic        cfg_valid = 1'b0;
    logic [5:0]  cfg_nint = '0;
    logic [5:0]  cfg_nfp = '0;
    logic        setvl_valid = 1'b0;
    logic [15:0] setvl_len = '0;
    logic [VW-1:0] vlmax;
    logic [VW-1:0] vl;
    logic [3:0]  bank_count;
    logic [31:0] cfg_rdata;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails = 0;

    always #(PER/2) clk = ~clk;

    vlcfg_unit #(.THREAD_MAX(TMAX)) dut (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .cfg_valid(cfg_valid), .cfg_nint(cfg_nint), .cfg_nfp(cfg_nfp),
        .setvl_valid(setvl_valid), .setvl_len(setvl_len),
        .vlmax(vlmax), .vl(vl), .bank_count(bank_count),
        .cfg_rdata(cfg_rdata), .busy(busy), .done(done)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pop8(int m);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (m >> i) & 1;
        return n;
    endfunction

    function automatic int ref_vlmax(int ni, int nf, int m);
        int s = ni + nf;
        int q = (s < 2) ? 256 : 256 / (s - 1);
        int v = q * pop8(m);
        return (v > TMAX) ? TMAX : v;
    endfunction

    // behavioural reference state
    int  m_mask, m_ni, m_nf, a_ni, a_nf, p_ni, p_nf, m_vl, m_cnt, m_done;
    int  m_vmax;
    bit  m_live = 0;
    bit  m_wasbusy;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 255; m_ni = 32; m_nf = 32; a_ni = 32; a_nf = 32;
            p_ni = 32; p_nf = 32; m_vl = 0; m_cnt = 0; m_done = 0; m_live = 1;
        end else begin
            m_vmax    = ref_vlmax(a_ni, a_nf, m_mask);
            m_wasbusy = (m_cnt > 0);
            if (setvl_valid && !m_wasbusy)
                m_vl = (int'(setvl_len) < m_vmax) ? int'(setvl_len) : m_vmax;
            if (mask_wr) m_mask = int'(mask_wdata) & 255;
            m_done = 0;
            if (m_wasbusy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    a_ni = p_ni; a_nf = p_nf; m_done = 1;
                end
            end else if (cfg_valid) begin
                m_ni = cfg_nint; m_nf = cfg_nfp; p_ni = cfg_nint; p_nf = cfg_nfp;
                m_cnt = 9;
            end
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (m_live) begin
            chk("R2 bank_count", bank_count, pop8(m_mask));
            chk("R4 vlmax", vlmax, ref_vlmax(a_ni, a_nf, m_mask));
            chk("R7 vl", vl, m_vl);
            chk("R9 cfg_rdata", cfg_rdata, (m_nf << 18) | (m_ni << 12) | m_vl);
            chk("R3 busy", busy, (m_cnt > 0) ? 1 : 0);
            chk("R3 done", done, m_done);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_setvl(int n);
        setvl_valid = 1'b1; setvl_len = 16'(n);
        step();
        setvl_valid = 1'b0;
    endtask

    task automatic do_mask(int m);
        mask_wr = 1'b1; mask_wdata = 16'(m);
        step();
        mask_wr = 1'b0;
    endtask

    task automatic do_cfg(int ni, int nf);
        cfg_valid = 1'b1; cfg_nint = 6'(ni); cfg_nfp = 6'(nf);
        step();
        cfg_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 30 && !done; i++) step();
    endtask

    initial begin
        #(PER * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 bank_count", bank_count, 8);
        chk("R1 vlmax", vlmax, 32);
        chk("R1 vl", vl, 0);
        chk("R1 cfg_rdata", cfg_rdata, 32'h0082_0000);
        chk("R1 busy", busy, 0);

        do_setvl(10);   chk("R7 short request", vl, 10);
        do_setvl(100);  chk("R7 long request", vl, 32);

        do_mask(16'hAB0F);
        chk("R2 upper bits dropped", bank_count, 4);
        chk("R2 vlmax follows mask", vlmax, 16);
        do_setvl(20);   chk("R7 after mask", vl, 16);

        do_cfg(63, 63);
        chk("R3 busy after accept", busy, 1);
        chk("R9 packed counts", cfg_rdata, (63 << 18) | (63 << 12) | 16);
        chk("R3 old vlmax kept", vlmax, 16);
        do_setvl(3);    chk("R8 setvl ignored", vl, 16);
        do_cfg(1, 1);   chk("R8 cfg ignored", cfg_rdata, (63 << 18) | (63 << 12) | 16);
        wait_done();
        chk("R4 divided budget", vlmax, 8);
        step();
        chk("R3 done single pulse", done, 0);

        do_cfg(1, 0);
        n = 0;
        while (busy && n < 30) begin step(); n++; end
        chk("R3 busy length", n, 9);
        chk("R3 done at fall", done, 1);
        chk("R5 small sum", vlmax, 1024);
        do_mask(16'h00FF);
        chk("R6 clamp", vlmax, 1024);
        do_setvl(5000); chk("R7 huge request", vl, 1024);
        do_mask(16'h0001);
        chk("R5 one bank", vlmax, 256);
        do_cfg(0, 0); wait_done();
        chk("R5 zero counts", vlmax, 256);
        do_cfg(2, 0); wait_done();
        chk("R4 sum two", vlmax, 256);
        do_cfg(10, 7); wait_done();
        chk("R4 sum seventeen", vlmax, 16);
        do_mask(16'h0000);
        chk("R2 no banks", vlmax, 0);
        do_setvl(5);    chk("R7 zero max", vl, 0);

        // mixed random traffic, checked every cycle by the reference
        for (int c = 0; c < 3000; c++) begin
            mask_wr     = ($urandom_range(0, 9) == 0);
            mask_wdata  = 16'($urandom);
            cfg_valid   = ($urandom_range(0, 7) == 0);
            cfg_nint    = 6'($urandom);
            cfg_nfp     = 6'($urandom);
            setvl_valid = ($urandom_range(0, 2) == 0);
            setvl_len   = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 300));
            step();
        end
        mask_wr = 1'b0; cfg_valid = 1'b0; setvl_valid = 1'b0;
        repeat (12) step();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule